// File: doc/BRIEF.md
# Two-Level Rate-Shaping Queue Scheduler

This block decides which of sixteen leaf queues is served next. The leaves are grouped four to a parent node, for example the logical interfaces that share one physical port. Every node, leaf or parent, carries three controls. A committed rate is a minimum guarantee that is honoured before anything else. A peak rate is a hard ceiling. A weight sets the node's share of the bandwidth left over once the guarantees are met. Both rates are kept as token buckets. A periodic refill tick adds a per-node amount to each bucket, and a per-node burst size caps it.

A client raises a dequeue request with the length of the packet it is about to send. The scheduler first picks a parent and then a child under that parent. It registers the chosen queue index and a valid flag on the same clock edge. It also charges the packet length to the buckets of both the chosen leaf and its parent. A new request can be presented in every cycle.

Top module: `rate_shaper_sched`

## Requirements
- R1: After reset, sel_valid is low, sel_queue is 0, and every bucket and excess credit is zero. A request made before the first refill tick therefore gets no selection.
- R2: A request sampled at a clock edge produces its result (sel_valid, sel_queue) at that same edge. Requests in consecutive cycles each get their own result. A cycle with no request leaves sel_valid low after the next edge.
- R3: A leaf whose backlog bit is low is never selected. A parent with no eligible child is skipped. When nothing is eligible, a request leaves sel_valid low.
- R4: A leaf or parent whose peak bucket is zero or below is not selected.
- R5: At each level, eligible nodes that hold positive committed tokens win over all others, and among them the choice is round robin starting just after the previous committed winner at that level. The queue index is parent*4+child, and backlog bit k belongs to queue k.
- R6: When no node at a level holds committed tokens, the eligible node with the largest excess credit wins, and a tie goes to the lowest index. Each tick adds the node's weight to its credit, capped at the node's burst. An excess win subtracts the packet length from the credit.
- R7: Each tick adds the committed and peak refill amounts to the matching buckets, and each bucket saturates at the node's burst size. In every config vector, node n occupies field n; nodes 0 to 15 are leaves (queue index) and nodes 16 to 19 are parents 0 to 3.
- R8: A selection subtracts the packet length from both buckets of the chosen leaf and of its parent. A bucket never falls below the floor of -2048.
- R9: When a tick and a selection fall in the same cycle, the decision uses the tokens held before that cycle. The bucket is first refilled and capped, and only then is the length subtracted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refill_tick | input | 1 | One-cycle pulse that refills all buckets and credits |
| backlog | input | 16 | Per-queue non-empty flags |
| deq_req | input | 1 | Dequeue request |
| deq_len | input | 12 | Packet length charged to the chosen leaf and its parent |
| cfg_cir_inc | input | 160 | Committed refill amount per node, 8 bits each |
| cfg_pir_inc | input | 160 | Peak refill amount per node, 8 bits each |
| cfg_burst | input | 320 | Burst cap per node, 16 bits each, at most 32767 |
| cfg_weight | input | 80 | Excess-sharing weight per node, 4 bits each |
| sel_valid | output | 1 | A queue was chosen for the request of the previous cycle |
| sel_queue | output | 4 | Index of the chosen queue |

## Verification
A refill tick and a granted dequeue can fall in the same cycle, and then each bucket has to both rise and fall on that one edge. The bench first refills a leaf's peak bucket to its cap. It then raises the tick together with a 60-unit request, and follows with a 40-unit request and a 1-unit request. The last of these must be refused: if the order were subtract-then-cap, the leaf would still hold tokens. The order is therefore judged from the leaf's later eligibility at the ports.

// File: rtl/hsched_pkg.sv
package hsched_pkg;

  // One bucket update: optional refill with saturation, then optional charge, then floor clamp.
  function automatic int tok_step(input int cur, input logic tick, input int inc,
                                  input int cap, input logic take, input int len,
                                  input int floor_v);
    int v;
    v = cur;
    if (tick) begin
      v = v + inc;
      if (v > cap) v = cap;
    end
    if (take) v = v - len;
    if (v < floor_v) v = floor_v;
    return v;
  endfunction

endpackage

// File: rtl/hsched_bucket.sv
module hsched_bucket
  import hsched_pkg::*;
#(
  parameter int TOK_W = 16,
  parameter int INC_W = 8,
  parameter int LEN_W = 12,
  parameter int FLOOR = -2048
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [INC_W-1:0]        inc,
  input  logic [TOK_W-1:0]        burst,
  input  logic                    take,
  input  logic [LEN_W-1:0]        len,
  output logic signed [TOK_W-1:0] tokens
);

  logic signed [TOK_W-1:0] tok_nxt;
  logic                    tok_en;

  always_comb begin
    tok_en  = tick | take;
    tok_nxt = TOK_W'(tok_step(int'(tokens), tick, int'(inc), int'(burst), take,
                              int'(len), FLOOR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tokens <= '0;
    else if (tok_en) tokens <= tok_nxt;
  end

  AST_REFILL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && !$past(take)) |-> (int'(tokens) <= int'($past(burst)))); // R7

  AST_TAKE_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(take) && !$past(tick)) |-> (tokens <= $past(tokens))); // R8

endmodule

// File: rtl/hsched_arb.sv
module hsched_arb
  import hsched_pkg::*;
#(
  parameter int N     = 4,
  parameter int TOK_W = 16,
  parameter int WT_W  = 4,
  parameter int LEN_W = 12,
  parameter int FLOOR = -2048,
  localparam int IDX_W = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [N-1:0]       elig,
  input  logic [N-1:0]       commit,
  input  logic [N*WT_W-1:0]  weight,
  input  logic [N*TOK_W-1:0] cap,
  input  logic               take,
  input  logic [LEN_W-1:0]   len,
  output logic               gnt_valid,
  output logic [IDX_W-1:0]   gnt_idx
);

  logic [IDX_W-1:0]        ptr, ptr_nxt;
  logic signed [TOK_W-1:0] credit [N];
  logic                    cm_hit, ex_hit;
  logic [IDX_W-1:0]        cm_idx, ex_idx;
  logic signed [TOK_W-1:0] best;

  // Committed pass: round robin from the pointer.
  always_comb begin
    cm_hit = 1'b0;
    cm_idx = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr) + k) % N;
      if (!cm_hit && commit[j]) begin
        cm_hit = 1'b1;
        cm_idx = IDX_W'(j);
      end
    end
  end

  // Excess pass: largest credit, lowest index on ties.
  always_comb begin
    ex_hit = 1'b0;
    ex_idx = '0;
    best   = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!ex_hit || credit[i] > best)) begin
        ex_hit = 1'b1;
        ex_idx = IDX_W'(i);
        best   = credit[i];
      end
    end
  end

  always_comb begin
    gnt_valid = |elig;
    gnt_idx   = cm_hit ? cm_idx : ex_idx;
    ptr_nxt   = ptr;
    if (take && cm_hit) ptr_nxt = (cm_idx == IDX_W'(N-1)) ? '0 : cm_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (take) ptr <= ptr_nxt;
  end

  for (genvar i = 0; i < N; i++) begin : g_cred
    logic                    c_take;
    logic signed [TOK_W-1:0] c_nxt;
    always_comb begin
      c_take = take && !cm_hit && (ex_idx == IDX_W'(i));
      c_nxt  = TOK_W'(tok_step(int'(credit[i]), tick, int'(weight[i*WT_W +: WT_W]),
                               int'(cap[i*TOK_W +: TOK_W]), c_take, int'(len), FLOOR));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             credit[i] <= '0;
      else if (tick || take)  credit[i] <= c_nxt;
    end
  end

  AST_GNT_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> elig[gnt_idx]); // R3

  AST_COMMIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (|commit) |-> commit[gnt_idx]); // R5

endmodule

// File: rtl/rate_shaper_sched.sv
module rate_shaper_sched
  import hsched_pkg::*;
#(
  parameter int N_PAR     = 4,
  parameter int N_CHD     = 4,
  parameter int TOK_W     = 16,
  parameter int INC_W     = 8,
  parameter int WT_W      = 4,
  parameter int LEN_W     = 12,
  parameter int TOK_FLOOR = -2048,
  localparam int N_LEAF = N_PAR * N_CHD,
  localparam int N_NODE = N_LEAF + N_PAR,
  localparam int Q_W    = $clog2(N_LEAF),
  localparam int P_W    = $clog2(N_PAR),
  localparam int C_W    = $clog2(N_CHD)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      refill_tick,
  input  logic [N_LEAF-1:0]         backlog,
  input  logic                      deq_req,
  input  logic [LEN_W-1:0]          deq_len,
  input  logic [N_NODE*INC_W-1:0]   cfg_cir_inc,
  input  logic [N_NODE*INC_W-1:0]   cfg_pir_inc,
  input  logic [N_NODE*TOK_W-1:0]   cfg_burst,
  input  logic [N_NODE*WT_W-1:0]    cfg_weight,
  output logic                      sel_valid,
  output logic [Q_W-1:0]            sel_queue
);

  logic signed [TOK_W-1:0] cm_tok [N_NODE];
  logic signed [TOK_W-1:0] pk_tok [N_NODE];
  logic [N_NODE-1:0]       take_node;
  logic [N_LEAF-1:0]       leaf_elig, leaf_cm;
  logic [N_PAR-1:0]        par_elig, par_cm, chd_valid;
  logic [C_W-1:0]          chd_idx [N_PAR];
  logic                    par_valid;
  logic [P_W-1:0]          par_idx;
  logic                    fire;
  logic [Q_W-1:0]          pick_q;
  logic                    sel_valid_nxt;

  // Token buckets for every node.
  for (genvar n = 0; n < N_NODE; n++) begin : g_node
    hsched_bucket #(.TOK_W(TOK_W), .INC_W(INC_W), .LEN_W(LEN_W), .FLOOR(TOK_FLOOR)) u_cm (
      .clk(clk), .rst_n(rst_n), .tick(refill_tick),
      .inc(cfg_cir_inc[n*INC_W +: INC_W]), .burst(cfg_burst[n*TOK_W +: TOK_W]),
      .take(take_node[n]), .len(deq_len), .tokens(cm_tok[n]));
    hsched_bucket #(.TOK_W(TOK_W), .INC_W(INC_W), .LEN_W(LEN_W), .FLOOR(TOK_FLOOR)) u_pk (
      .clk(clk), .rst_n(rst_n), .tick(refill_tick),
      .inc(cfg_pir_inc[n*INC_W +: INC_W]), .burst(cfg_burst[n*TOK_W +: TOK_W]),
      .take(take_node[n]), .len(deq_len), .tokens(pk_tok[n]));
  end

  for (genvar l = 0; l < N_LEAF; l++) begin : g_leaf
    assign leaf_elig[l] = backlog[l] && (pk_tok[l] > 0);
    assign leaf_cm[l]   = leaf_elig[l] && (cm_tok[l] > 0);
    assign take_node[l] = fire && (pick_q == Q_W'(l));
  end

  // Child-level arbiters, one per parent.
  for (genvar p = 0; p < N_PAR; p++) begin : g_par
    hsched_arb #(.N(N_CHD), .TOK_W(TOK_W), .WT_W(WT_W), .LEN_W(LEN_W), .FLOOR(TOK_FLOOR)) u_chd (
      .clk(clk), .rst_n(rst_n), .tick(refill_tick),
      .elig(leaf_elig[p*N_CHD +: N_CHD]), .commit(leaf_cm[p*N_CHD +: N_CHD]),
      .weight(cfg_weight[p*N_CHD*WT_W +: N_CHD*WT_W]),
      .cap(cfg_burst[p*N_CHD*TOK_W +: N_CHD*TOK_W]),
      .take(fire && (par_idx == P_W'(p))), .len(deq_len),
      .gnt_valid(chd_valid[p]), .gnt_idx(chd_idx[p]));
    assign par_elig[p]          = chd_valid[p] && (pk_tok[N_LEAF+p] > 0);
    assign par_cm[p]            = par_elig[p] && (cm_tok[N_LEAF+p] > 0);
    assign take_node[N_LEAF+p]  = fire && (par_idx == P_W'(p));
  end

  // Parent-level arbiter.
  hsched_arb #(.N(N_PAR), .TOK_W(TOK_W), .WT_W(WT_W), .LEN_W(LEN_W), .FLOOR(TOK_FLOOR)) u_par (
    .clk(clk), .rst_n(rst_n), .tick(refill_tick),
    .elig(par_elig), .commit(par_cm),
    .weight(cfg_weight[N_LEAF*WT_W +: N_PAR*WT_W]),
    .cap(cfg_burst[N_LEAF*TOK_W +: N_PAR*TOK_W]),
    .take(fire), .len(deq_len),
    .gnt_valid(par_valid), .gnt_idx(par_idx));

  always_comb begin
    fire          = deq_req && par_valid;
    pick_q        = Q_W'(int'(par_idx) * N_CHD + int'(chd_idx[par_idx]));
    sel_valid_nxt = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_queue <= '0;
    end else begin
      sel_valid <= sel_valid_nxt;
      if (fire) sel_queue <= pick_q;
    end
  end

  AST_SEL_BACKLOG: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (|($past(backlog) & (N_LEAF'(1) << sel_queue)))); // R3

  AST_SEL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> $past(deq_req)); // R2

endmodule

// File: tb/rate_shaper_sched_bench.sv
module rate_shaper_sched_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         refill_tick;
  logic [15:0]  backlog;
  logic         deq_req;
  logic [11:0]  deq_len;
  logic [159:0] cfg_cir_inc, cfg_pir_inc;
  logic [319:0] cfg_burst;
  logic [79:0]  cfg_weight;
  logic         sel_valid;
  logic [3:0]   sel_queue;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rate_shaper_sched u_rate_shaper_sched (
    .clk(clk), .rst_n(rst_n), .refill_tick(refill_tick), .backlog(backlog),
    .deq_req(deq_req), .deq_len(deq_len), .cfg_cir_inc(cfg_cir_inc),
    .cfg_pir_inc(cfg_pir_inc), .cfg_burst(cfg_burst), .cfg_weight(cfg_weight),
    .sel_valid(sel_valid), .sel_queue(sel_queue));

  // {tick, req, len[11:0], backlog[15:0], exp_valid, exp_queue[3:0]}
  localparam int TBL_N = 7;
  localparam logic [34:0] TBL [TBL_N] = '{
    {1'b1, 1'b0, 12'd0,  16'h0000, 1'b0, 4'd0},  // refill only
    {1'b0, 1'b1, 12'd10, 16'h0023, 1'b1, 4'd0},  // R5 committed rr, parent 0 leaf 0
    {1'b0, 1'b1, 12'd10, 16'h0023, 1'b1, 4'd5},  // R5 parent rr moves to parent 1
    {1'b0, 1'b1, 12'd10, 16'h0023, 1'b1, 4'd1},  // R5 rr skips empty parents, leaf rr
    {1'b0, 1'b1, 12'd10, 16'h0023, 1'b1, 4'd5},  // R2 back-to-back, leaf via excess
    {1'b0, 1'b0, 12'd0,  16'h0023, 1'b0, 4'd0},  // R2 no request
    {1'b0, 1'b1, 12'd10, 16'h0000, 1'b0, 4'd0}   // R3 nothing backlogged
  };

  task automatic check_sel(input string tag, input logic ev, input logic [3:0] eq);
    checks++;
    if (sel_valid !== ev || (ev && sel_queue !== eq)) begin
      failures++;
      $display("FAIL %s: valid=%0b queue=%0d expected valid=%0b queue=%0d",
               tag, sel_valid, sel_queue, ev, eq);
    end
  endtask

  task automatic step(input logic t, input logic r, input logic [11:0] l, input logic [15:0] bl);
    @(negedge clk);
    refill_tick = t;
    deq_req     = r;
    deq_len     = l;
    backlog     = bl;
    @(posedge clk);
    #1;
  endtask

  task automatic set_cfg(input int lc, input int lp, input int lb,
                         input int pc, input int pp, input int pb);
    for (int n = 0; n < 20; n++) begin
      cfg_cir_inc[n*8 +: 8]   = (n < 16) ? 8'(lc) : 8'(pc);
      cfg_pir_inc[n*8 +: 8]   = (n < 16) ? 8'(lp) : 8'(pp);
      cfg_burst[n*16 +: 16]   = (n < 16) ? 16'(lb) : 16'(pb);
      cfg_weight[n*4 +: 4]    = 4'd1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    refill_tick = 1'b0; deq_req = 1'b0; deq_len = '0; backlog = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    refill_tick = 1'b0; deq_req = 1'b0; deq_len = '0; backlog = '0;
    set_cfg(10, 100, 100, 40, 200, 200);
    do_reset();

    // R1: reset state, and no selection before the first refill
    #1;
    check_sel("R1 reset outputs", 1'b0, 4'd0);
    checks++;
    if (sel_queue !== 4'd0) begin
      failures++;
      $display("FAIL R1 reset queue: actual=%0d expected=0", sel_queue);
    end
    step(1'b0, 1'b1, 12'd5, 16'hFFFF);
    check_sel("R1 request before refill", 1'b0, 4'd0);

    // Table walk: committed round robin, back-to-back, idle and empty cases
    do_reset();
    for (int i = 0; i < TBL_N; i++) begin
      logic t, r, ev;
      logic [11:0] l;
      logic [15:0] bl;
      logic [3:0] eq;
      {t, r, l, bl, ev, eq} = TBL[i];
      step(t, r, l, bl);
      check_sel($sformatf("R2/R3/R5 table row %0d", i), ev, eq);
    end

    // R4/R7/R9: peak limit and refill-then-charge order in one cycle
    do_reset();
    step(1'b1, 1'b0, 12'd0, 16'h0001);
    check_sel("R7 refill without request", 1'b0, 4'd0);
    step(1'b1, 1'b1, 12'd60, 16'h0001);
    check_sel("R9 tick with request uses prior tokens", 1'b1, 4'd0);
    step(1'b0, 1'b1, 12'd40, 16'h0001);
    check_sel("R8 second charge", 1'b1, 4'd0);
    step(1'b0, 1'b1, 12'd1, 16'h0001);
    check_sel("R4/R9 peak exhausted after cap-then-charge", 1'b0, 4'd0);
    step(1'b1, 1'b0, 12'd0, 16'h0001);
    step(1'b0, 1'b1, 12'd1, 16'h0001);
    check_sel("R7 refill restores eligibility", 1'b1, 4'd0);

    // R8: floor bounds the debt, recovery after exactly 21 refills
    do_reset();
    step(1'b1, 1'b0, 12'd0, 16'h0001);
    step(1'b0, 1'b1, 12'd4095, 16'h0001);
    check_sel("R8 large packet selected", 1'b1, 4'd0);
    for (int k = 0; k < 20; k++) step(1'b1, 1'b0, 12'd0, 16'h0001);
    step(1'b0, 1'b1, 12'd1, 16'h0001);
    check_sel("R8 still below zero after 20 refills", 1'b0, 4'd0);
    step(1'b1, 1'b0, 12'd0, 16'h0001);
    step(1'b0, 1'b1, 12'd1, 16'h0001);
    check_sel("R8 floor lets 21st refill recover", 1'b1, 4'd0);

    // R6: excess sharing by credit, ties to lowest index
    set_cfg(0, 100, 100, 40, 200, 200);
    cfg_weight[0*4 +: 4] = 4'd3;
    cfg_weight[1*4 +: 4] = 4'd1;
    cfg_weight[2*4 +: 4] = 4'd3;
    do_reset();
    step(1'b1, 1'b0, 12'd0, 16'h0007);
    step(1'b0, 1'b1, 12'd5, 16'h0007);
    check_sel("R6 tie goes to lowest index", 1'b1, 4'd0);
    step(1'b0, 1'b1, 12'd5, 16'h0007);
    check_sel("R6 largest credit", 1'b1, 4'd2);
    step(1'b0, 1'b1, 12'd5, 16'h0007);
    check_sel("R6 lighter weight gets its turn", 1'b1, 4'd1);
    step(1'b0, 1'b1, 12'd5, 16'h0007);
    check_sel("R6 tie again to lowest index", 1'b1, 4'd0);
    step(1'b0, 1'b0, 12'd0, 16'h0000);

    finish_run();
  end

endmodule